// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog with two consecutive timeout windows, both counted in prescaled clock ticks. The first window is the pretimeout window. Software keeps the system alive by writing to a kick register during this window, and each kick starts the window again from zero. When the first window runs out, a pretimeout interrupt is raised and the grace window begins. Kicks have no effect during the grace window. The only way to avoid a reset at that point is to clear the enable bit.

When the grace window runs out, the block raises a timeout interrupt. In the same cycle it emits a one-cycle reset request on one of three outputs: whole chip, processor plus its crypto engine, or a software-only restart that resets no hardware. A control field picks the output. After the request the block clears its own enable bit and goes back to idle.

Software reaches the block through a small word-wide register port. Writes are a single cycle. Reads are combinational and addressed separately from writes.

The state machine has four states:
- IDLE: disarmed.
- PH1: pretimeout window.
- PH2: grace window.
- FIRE: the one-cycle reset request.

Its transitions are:
- arm: IDLE to PH1 when enabled.
- kick: PH1 to PH1 with the count restarted.
- expire1: PH1 to PH2 on the last tick of the window.
- expire2: PH2 to FIRE on the last tick of the window.
- disarm: PH1 or PH2 to IDLE when disabled.
- retire: FIRE to IDLE.

Top module: `wdt_dual_phase`

## Requirements
- R1: After reset the control register reads 0: disabled, reset target processor, both windows one tick long. Both interrupts and all three reset outputs are low.
- R2: The prescaler gives one tick every 2^PRE_W cycles while the block is in PH1 or PH2. The prescaler is held at zero whenever the block is disabled or idle, so each arming starts from a fresh prescaler.
- R3: Control register (address 0) layout:
  - bit 0: enable.
  - bits 2:1: reset target.
  - bits 8:4: window 1 length minus one (L-1).
  - bits 16:12: window 2 length minus one (M-1).

  A write to the control register at clock edge E enters PH1 at edge E+1. The pretimeout interrupt rises at edge E+1+L*2^PRE_W.
- R4: PH2 lasts M*2^PRE_W cycles. The block then enters FIRE, where the selected reset output is high for exactly one cycle and the timeout interrupt rises.
- R5: A write to the kick register (address 1, any data) during PH1, on a cycle without an expiry tick, restarts window 1: the tick count and the prescaler both return to zero.
- R6: A kick during PH2 has no effect: the reset request arrives in the same cycle it would have without the kick.
- R7: A kick in the same cycle as the window-1 expiry tick wins. The block stays in PH1, the pretimeout interrupt does not rise, and window 1 restarts from zero.
- R8: Clearing the enable bit in PH1 or PH2 returns the block to IDLE. No reset request follows.
- R9: Reset target codes:

  | Code | Output |
  |------|--------|
  | 0 | `rst_req_cpu` |
  | 1 | `rst_req_chip` |
  | 2 | `rst_req_soft` |
  | 3 | `rst_req_cpu` |

  At most one reset output is ever high.
- R10: When the reset request is issued, the enable bit clears itself. The block returns to IDLE and issues no further request until software enables it again.
- R11: Status register (address 2):
  - bit 0: pretimeout pending.
  - bit 1: timeout pending.
  - bits 3:2: state code (0 IDLE, 1 PH1, 2 PH2, 3 FIRE).

  The pending bits drive the interrupt outputs. They stay set until software writes 1 to the same bit position, and writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, combinational |
| irq_pretimeout | output | 1 | Window 1 expired, sticky |
| irq_timeout | output | 1 | Window 2 expired, sticky |
| rst_req_chip | output | 1 | One-cycle whole-chip reset request |
| rst_req_cpu | output | 1 | One-cycle processor reset request |
| rst_req_soft | output | 1 | One-cycle software restart request |

## Verification
The bench builds the block with PRE_W = 2, so each tick is four clock cycles. Even the longest setting, 32 ticks per window, then completes in a few hundred cycles. This makes the full 1-to-32 length range reachable, and every expected edge can be counted exactly from the formula in R3 and R4. With ticks this short, the bench can also drive a kick on precisely the expiry cycle, inside the grace window, or between ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2,
        PH_FIRE = 2'd3
    } wdt_phase_e;

    localparam logic [1:0] RM_CPU  = 2'd0;
    localparam logic [1:0] RM_CHIP = 2'd1;
    localparam logic [1:0] RM_SOFT = 2'd2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_KICK = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int CTL_EN_B   = 0;
    localparam int CTL_MODE_B = 1;
    localparam int CTL_P1_B   = 4;
    localparam int CTL_P2_B   = 12;
    localparam int ST_PEND_B  = 0;
    localparam int ST_PHASE_B = 2;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_W = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] cnt_q;

    assign tick = run && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a stopped prescaler is held at zero
    a_r2_prescale_cleared : assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_phase_fsm.sv
module wdt_phase_fsm
    import wdt_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ping,
    input  logic             tick,
    input  logic [LEN_W-1:0] p1_last,
    input  logic [LEN_W-1:0] p2_last,
    input  logic [1:0]       mode,
    output wdt_phase_e       phase,
    output logic             run,
    output logic             restart,
    output logic             exp1,
    output logic             exp2,
    output logic             rst_chip,
    output logic             rst_cpu,
    output logic             rst_soft
);
    wdt_phase_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    assign phase = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        exp1    = 1'b0;
        exp2    = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (en) state_d = PH_ONE;
            end
            PH_ONE: begin
                if (!en) begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end else if (ping) begin
                    restart = 1'b1;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= p1_last) begin
                        state_d = PH_TWO;
                        cnt_d   = '0;
                        exp1    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_TWO: begin
                if (!en) begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= p2_last) begin
                        state_d = PH_FIRE;
                        cnt_d   = '0;
                        exp2    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_FIRE: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
            default: begin
                state_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        run      = en && ((state_q == PH_ONE) || (state_q == PH_TWO));
        rst_chip = 1'b0;
        rst_cpu  = 1'b0;
        rst_soft = 1'b0;
        if (state_q == PH_FIRE) begin
            unique case (mode)
                RM_CHIP: rst_chip = 1'b1;
                RM_SOFT: rst_soft = 1'b1;
                default: rst_cpu  = 1'b1;
            endcase
        end
    end

    // R10: the reset state lasts one cycle
    a_r10_fire_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FIRE) |=> (state_q == PH_IDLE));

    // R4: the grace window is only reached from the pretimeout window
    a_r4_ph2_entry : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_TWO && $past(state_q) != PH_TWO) |-> ($past(state_q) == PH_ONE));

    // R6: a kick in the grace window leaves the count alone
    a_r6_kick_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_TWO && en && ping && !tick) |=> (state_q == PH_TWO && cnt_q == $past(cnt_q)));

    // R8: disarming drops back to idle
    a_r8_disarm : assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state_q != PH_IDLE) |=> (state_q == PH_IDLE));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 2,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic             exp1,
    input  logic             exp2,
    input  wdt_phase_e       phase,
    output logic             en,
    output logic [1:0]       mode,
    output logic [LEN_W-1:0] p1_last,
    output logic [LEN_W-1:0] p2_last,
    output logic             ping,
    output logic [1:0]       pend,
    output logic [DW-1:0]    rd_data
);
    logic       wr_ctrl, wr_stat;
    logic [1:0] clr;

    assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
    assign wr_stat = wr_en && (wr_addr == AW'(A_STAT));
    assign ping    = wr_en && (wr_addr == AW'(A_KICK));
    assign clr     = wr_stat ? wr_data[ST_PEND_B +: 2] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            mode    <= RM_CPU;
            p1_last <= '0;
            p2_last <= '0;
        end else begin
            if (wr_ctrl) begin
                en      <= wr_data[CTL_EN_B];
                mode    <= wr_data[CTL_MODE_B +: 2];
                p1_last <= wr_data[CTL_P1_B +: LEN_W];
                p2_last <= wr_data[CTL_P2_B +: LEN_W];
            end
            if (exp2) en <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 2'b00;
        end else begin
            pend <= (pend & ~clr) | {exp2, exp1};
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            AW'(A_CTRL): begin
                rd_data[CTL_EN_B]             = en;
                rd_data[CTL_MODE_B +: 2]      = mode;
                rd_data[CTL_P1_B +: LEN_W]    = p1_last;
                rd_data[CTL_P2_B +: LEN_W]    = p2_last;
            end
            AW'(A_STAT): begin
                rd_data[ST_PEND_B +: 2]       = pend;
                rd_data[ST_PHASE_B +: 2]      = phase;
            end
            default: rd_data = '0;
        endcase
    end

    // R10: the enable bit drops after the reset request is issued
    a_r10_self_disable : assert property (@(posedge clk) disable iff (!rst_n)
        exp2 |=> !en);

    // R11: pretimeout status holds until cleared by a 1
    a_r11_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !clr[0]) |=> pend[0]);

endmodule

// File: rtl/wdt_dual_phase.sv
module wdt_dual_phase
    import wdt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 2,
    parameter int LEN_W = 5,
    parameter int PRE_W = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_pretimeout,
    output logic          irq_timeout,
    output logic          rst_req_chip,
    output logic          rst_req_cpu,
    output logic          rst_req_soft
);
    logic             en, ping, tick, run, restart, exp1, exp2;
    logic [1:0]       mode, pend;
    logic [LEN_W-1:0] p1_last, p2_last;
    wdt_phase_e       phase;

    wdt_regs #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .exp1    (exp1),
        .exp2    (exp2),
        .phase   (phase),
        .en      (en),
        .mode    (mode),
        .p1_last (p1_last),
        .p2_last (p2_last),
        .ping    (ping),
        .pend    (pend),
        .rd_data (rd_data)
    );

    wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    wdt_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ping     (ping),
        .tick     (tick),
        .p1_last  (p1_last),
        .p2_last  (p2_last),
        .mode     (mode),
        .phase    (phase),
        .run      (run),
        .restart  (restart),
        .exp1     (exp1),
        .exp2     (exp2),
        .rst_chip (rst_req_chip),
        .rst_cpu  (rst_req_cpu),
        .rst_soft (rst_req_soft)
    );

    assign irq_pretimeout = pend[0];
    assign irq_timeout    = pend[1];

    // R9: never more than one reset target at a time
    a_r9_one_target : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req_chip, rst_req_cpu, rst_req_soft}));

    // R4: a reset request coincides with a raised timeout interrupt
    a_r4_irq_with_reset : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_chip || rst_req_cpu || rst_req_soft) |-> irq_timeout);

endmodule

// File: tb/wdt_dual_phase_test.sv
module wdt_dual_phase_test;
    import wdt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 2;
    localparam int DIV        = 1 << PRE_W;
    localparam int NVEC       = 6;
    // vector: [11:10] reset code, [9:5] L-1, [4:0] M-1
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd0, 5'd0,  5'd0},
        {2'd1, 5'd31, 5'd31},
        {2'd2, 5'd3,  5'd5},
        {2'd3, 5'd7,  5'd0},
        {2'd0, 5'd0,  5'd31},
        {2'd1, 5'd12, 5'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_pre, irq_to, r_chip, r_cpu, r_soft;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_dual_phase #(.DW(32), .AW(2), .LEN_W(5), .PRE_W(PRE_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .irq_pretimeout (irq_pre),
        .irq_timeout    (irq_to),
        .rst_req_chip   (r_chip),
        .rst_req_cpu    (r_cpu),
        .rst_req_soft   (r_soft)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] cw(input logic e, input logic [1:0] m,
                                       input logic [4:0] p1, input logic [4:0] p2);
        logic [31:0] w = '0;
        w[0] = e; w[2:1] = m; w[8:4] = p1; w[16:12] = p2;
        return w;
    endfunction

    // Counts negedges after a write; optionally kicks at index kick_at.
    task automatic watch(input int kick_at, input int limit, output int pre_at,
                         output int rst_at, output logic [2:0] which);
        pre_at = -1; rst_at = -1; which = '0;
        for (int n = 0; n < limit && rst_at < 0; n++) begin
            if (n == kick_at) begin
                wr_en = 1'b1; wr_addr = A_KICK; wr_data = 32'h1;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            if (irq_pre && pre_at < 0) pre_at = n + 1;
            if (r_chip || r_cpu || r_soft) begin
                rst_at = n + 1;
                which  = {r_chip, r_cpu, r_soft};
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pa, ra, L, M;
        logic [2:0] wh, exp_wh;
        logic [31:0] d;
        logic [1:0] m;

        repeat (3) @(negedge clk);
        // R1: reset state
        rd(A_CTRL, d);
        chk("R1 ctrl", d, 32'h0);
        chk("R1 outputs", {27'd0, irq_pre, irq_to, r_chip, r_cpu, r_soft}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after release", {27'd0, irq_pre, irq_to, r_chip, r_cpu, r_soft}, 32'h0);

        // R3 layout readback with enable low
        wr(A_CTRL, cw(1'b0, 2'd2, 5'd5, 5'd9));
        rd(A_CTRL, d);
        chk("R3 ctrl readback", d, 32'h0000_9054);

        // Table walk: R3, R4, R9, R10
        for (int i = 0; i < NVEC; i++) begin
            m = VEC[i][11:10];
            L = int'(VEC[i][9:5]) + 1;
            M = int'(VEC[i][4:0]) + 1;
            exp_wh = (m == 2'd1) ? 3'b100 : (m == 2'd2) ? 3'b001 : 3'b010;
            wr(A_STAT, 32'h3);
            wr(A_CTRL, cw(1'b1, m, VEC[i][9:5], VEC[i][4:0]));
            watch(-1, 2000, pa, ra, wh);
            chk("R3 pretimeout edge", pa, 1 + DIV*L);
            chk("R4 reset edge", ra, 1 + DIV*(L+M));
            chk("R9 target", {29'd0, wh}, {29'd0, exp_wh});
            chk("R4 timeout irq", {31'd0, irq_to}, 32'h1);
            @(negedge clk);
            chk("R4 one-cycle pulse", {29'd0, r_chip, r_cpu, r_soft}, 32'h0);
            rd(A_CTRL, d);
            chk("R10 enable cleared", {31'd0, d[0]}, 32'h0);
            rd(A_STAT, d);
            chk("R10 idle", {30'd0, d[3:2]}, 32'h0);
        end
        watch(-1, 100, pa, ra, wh);
        chk("R10 no further request", ra, -1);

        // R11: write-one-to-clear per bit
        wr(A_STAT, 32'h1);
        chk("R11 pre cleared", {31'd0, irq_pre}, 32'h0);
        chk("R11 timeout kept", {31'd0, irq_to}, 32'h1);
        wr(A_STAT, 32'h0);
        chk("R11 zero write no effect", {31'd0, irq_to}, 32'h1);
        wr(A_STAT, 32'h2);
        rd(A_STAT, d);
        chk("R11 both clear", {30'd0, d[1:0]}, 32'h0);

        // R5: kick between ticks in window 1 (L=3, M=2)
        wr(A_CTRL, cw(1'b1, 2'd0, 5'd2, 5'd1));
        watch(6, 2000, pa, ra, wh);
        chk("R5 restarted pretimeout", pa, 7 + DIV*3);
        chk("R5 restarted reset", ra, 7 + DIV*5);
        @(negedge clk); wr(A_STAT, 32'h3);

        // R7: kick on the expiry tick (L=1, M=2)
        wr(A_CTRL, cw(1'b1, 2'd0, 5'd0, 5'd1));
        watch(4, 2000, pa, ra, wh);
        chk("R7 kick wins pretimeout", pa, 5 + DIV*1);
        chk("R7 kick wins reset", ra, 5 + DIV*3);
        @(negedge clk); wr(A_STAT, 32'h3);

        // R6: kick inside the grace window (L=1, M=3)
        wr(A_CTRL, cw(1'b1, 2'd0, 5'd0, 5'd2));
        watch(9, 2000, pa, ra, wh);
        chk("R6 pretimeout", pa, 1 + DIV*1);
        chk("R6 reset unchanged", ra, 1 + DIV*4);
        @(negedge clk); wr(A_STAT, 32'h3);

        // R8: disarm in grace window (L=1, M=4)
        wr(A_CTRL, cw(1'b1, 2'd1, 5'd0, 5'd3));
        watch(-1, 7, pa, ra, wh);
        rd(A_STAT, d);
        chk("R8 in grace window", {30'd0, d[3:2]}, 32'h2);
        wr(A_CTRL, cw(1'b0, 2'd1, 5'd0, 5'd3));
        watch(-1, 80, pa, ra, wh);
        chk("R8 no reset after disarm", ra, -1);
        rd(A_STAT, d);
        chk("R8 idle after disarm", {30'd0, d[3:2]}, 32'h0);

        // R8 in window 1, then R2 fresh prescaler on re-arm
        wr(A_STAT, 32'h3);
        wr(A_CTRL, cw(1'b1, 2'd0, 5'd7, 5'd0));
        watch(-1, 6, pa, ra, wh);
        wr(A_CTRL, cw(1'b0, 2'd0, 5'd7, 5'd0));
        watch(-1, 60, pa, ra, wh);
        chk("R8 window 1 disarm no irq", pa, -1);
        chk("R8 window 1 disarm no reset", ra, -1);
        wr(A_CTRL, cw(1'b1, 2'd0, 5'd0, 5'd3));
        watch(-1, 2000, pa, ra, wh);
        chk("R2 fresh prescaler pretimeout", pa, 1 + DIV*1);
        chk("R2 fresh prescaler reset", ra, 1 + DIV*5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule